// File: doc/BRIEF.md
# Fixed-Priority Command Queue Arbiter with Zero-Jitter Preemption

This block decides which of six command queues supplies the next conversion command. A queue takes part only while it is armed, holds at least one command, and the destination buffer named by its head command has room. Among the queues that qualify, the lowest index always wins. A queue is armed by a one-cycle software trigger, or by its hardware trigger line under a per-queue edge or level mode. It stays armed until it is seen empty.

The grant is registered and held until the consumer accepts the command. Only at that command boundary does arbitration run again. Queue 0 has a separate preemption path. A trigger that arms an idle queue 0 drops the current grant and pulses an abort output that tells the converter and the destination buffers to discard their work. Arbitration then stays frozen for a fixed start-up window: a set number of system clocks, then the next converter clock tick. At that tick a start pulse is issued.

Each command carries an end-of-group bit. A group that is broken up before its last command raises a one-cycle coherency interrupt, and the interrupt names the queue whose group was broken. This happens when the grant passes to another queue, or when an abort arrives.

Top module: `fp_cmd_arbiter`

## Requirements
- R1: During and right after reset, `cmd_vld`, `abort`, `zj_start` and `coh_irq` are all low.
- R2: Queue i qualifies when it is armed, `q_nonempty[i]` is high, and `buf_free[q_dest[i*BW +: BW]]` is high. Destination field bit 0 selects the buffer when there are two buffers. At a re-evaluation the lowest qualifying index is granted. If no queue qualifies, `cmd_vld` goes low.
- R3: A high `sw_trig[i]` arms queue i at the next edge. An armed queue stays armed over any number of cycles until an edge at which `q_nonempty[i]` is low.
- R4: The hardware trigger mode of queue i is `hw_mode[2*i +: 2]`: 00 rising edge, 01 falling edge, 10 high level, 11 low level. A trigger line arms its queue only while `hw_en[i]` is high, and in any other condition it has no effect.
- R5: While `cmd_vld` is high and `cmd_rdy` is low, `gnt_idx` and `cmd_vld` hold, even if a higher-priority queue becomes armed. Re-evaluation happens at the edge after an accept (`cmd_vld` and `cmd_rdy` both high) or while `cmd_vld` is low.
- R6: A queue 0 trigger that arms an unarmed queue 0 makes `abort` high for exactly the next cycle and drops `cmd_vld` in that same cycle.
- R7: When `adc_tick` is held high, `zj_start` pulses for one cycle exactly 13 clock edges after the edge that raised `abort`. When `adc_tick` is low, the pulse waits for the first edge with `adc_tick` high after those 13 edges.
- R8: From the cycle `abort` is high through the cycle `zj_start` is high, `cmd_vld` stays low. After that, arbitration resumes.
- R9: An accepted command whose `q_eog` is 0 opens a group for its queue. A grant to another queue while the group is open, or an abort while the group is open, makes `coh_irq` pulse for one cycle with `coh_qid` set to the group's queue.
- R10: A queue 0 trigger, software or hardware, that arrives while queue 0 is already armed raises no abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_trig | input | NQ | Software trigger pulse per queue |
| hw_trig | input | NQ | Hardware trigger line per queue |
| hw_en | input | NQ | Hardware trigger enable per queue |
| hw_mode | input | 2*NQ | Hardware trigger mode, two bits per queue |
| q_nonempty | input | NQ | Queue holds at least one command |
| q_dest | input | NQ*BW | Destination buffer of each queue's head command |
| q_eog | input | NQ | End-of-group bit of each queue's head command |
| buf_free | input | NB | Destination buffer has room |
| adc_tick | input | 1 | One-cycle strobe per converter clock |
| cmd_rdy | input | 1 | Consumer accepts the granted command |
| gnt_idx | output | IW | Index of the granted queue |
| cmd_vld | output | 1 | A granted command is offered |
| abort | output | 1 | Abort current conversion and flush buffered commands |
| zj_start | output | 1 | Queue 0 conversion start pulse |
| coh_irq | output | 1 | Coherency violation pulse |
| coh_qid | output | IW | Queue whose group was broken |

## Verification
Two events can fall on the same edge: a queue 0 preemption and a coherency break. The bench opens a group on queue 3 by accepting a command whose end-of-group bit is 0, holds the grant, and then fires queue 0. It then expects `abort` and `coh_irq` together in one cycle, with `coh_qid` equal to 3. A second collision puts a command accept and a handover to a higher-priority queue on one edge. In that case the new grant and the coherency pulse must appear in the same cycle, and the pulse must clear one cycle later.

// File: rtl/fp_cmd_arbiter.sv
module fp_cmd_arbiter #(
  parameter int NQ = 6,
  parameter int NB = 2,
  parameter int ZJ_CYC = 13,
  localparam int IW = $clog2(NQ),
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int ZW = $clog2(ZJ_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NQ-1:0]   sw_trig,
  input  logic [NQ-1:0]   hw_trig,
  input  logic [NQ-1:0]   hw_en,
  input  logic [2*NQ-1:0] hw_mode,
  input  logic [NQ-1:0]   q_nonempty,
  input  logic [NQ*BW-1:0] q_dest,
  input  logic [NQ-1:0]   q_eog,
  input  logic [NB-1:0]   buf_free,
  input  logic            adc_tick,
  input  logic            cmd_rdy,
  output logic [IW-1:0]   gnt_idx,
  output logic            cmd_vld,
  output logic            abort,
  output logic            zj_start,
  output logic            coh_irq,
  output logic [IW-1:0]   coh_qid
);
  logic [NQ-1:0] armed, hw_prev, hw_evt, trig, elig;
  logic [ZW-1:0] zcnt;
  logic [IW-1:0] win, grp_q, grp_q_nx;
  logic zwait, grp_open, grp_open_nx, win_vld, zj_fire, accept, reeval, breaks;

  for (genvar i = 0; i < NQ; i++) begin : g_q
    logic ev;
    always_comb begin
      case (hw_mode[2*i +: 2])
        2'b00:   ev = hw_trig[i] & ~hw_prev[i];
        2'b01:   ev = ~hw_trig[i] & hw_prev[i];
        2'b10:   ev = hw_trig[i];
        default: ev = ~hw_trig[i];
      endcase
    end
    assign hw_evt[i] = hw_en[i] & ev;
    assign elig[i] = armed[i] & q_nonempty[i] & buf_free[q_dest[i*BW +: BW]];
  end

  always_comb begin
    win = '0;
    for (int i = NQ - 1; i >= 0; i--)
      if (elig[i]) win = IW'(i);
  end

  assign win_vld     = |elig;
  assign trig        = sw_trig | hw_evt;
  assign zj_fire     = trig[0] & ~armed[0] & ~zwait;
  assign accept      = cmd_vld & cmd_rdy;
  assign reeval      = ~cmd_vld | cmd_rdy;
  assign grp_open_nx = accept ? ~q_eog[gnt_idx] : grp_open;
  assign grp_q_nx    = accept ? gnt_idx : grp_q;
  assign breaks      = reeval & win_vld & grp_open_nx & (win != grp_q_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= '0;
      hw_prev  <= '0;
      zwait    <= 1'b0;
      zcnt     <= '0;
      grp_open <= 1'b0;
      grp_q    <= '0;
      gnt_idx  <= '0;
      cmd_vld  <= 1'b0;
      abort    <= 1'b0;
      zj_start <= 1'b0;
      coh_irq  <= 1'b0;
      coh_qid  <= '0;
    end else begin
      hw_prev  <= hw_trig;
      armed    <= (armed & q_nonempty) | trig;
      abort    <= zj_fire;
      zj_start <= 1'b0;
      coh_irq  <= 1'b0;
      grp_open <= grp_open_nx;
      grp_q    <= grp_q_nx;
      if (zj_fire) begin
        zwait    <= 1'b1;
        zcnt     <= ZW'(ZJ_CYC - 1);
        cmd_vld  <= 1'b0;
        grp_open <= 1'b0;
        if (grp_open_nx) begin
          coh_irq <= 1'b1;
          coh_qid <= grp_q_nx;
        end
      end else if (zwait) begin
        if (zcnt != '0) zcnt <= zcnt - 1'b1;
        else if (adc_tick) begin
          zwait    <= 1'b0;
          zj_start <= 1'b1;
        end
      end else if (reeval) begin
        cmd_vld <= win_vld;
        if (win_vld) gnt_idx <= win;
        if (breaks) begin
          coh_irq  <= 1'b1;
          coh_qid  <= grp_q_nx;
          grp_open <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/fp_cmd_arbiter_chk.sv
module fp_cmd_arbiter_chk #(
  parameter int NQ = 6,
  parameter int ZJ_CYC = 13,
  localparam int IW = $clog2(NQ),
  localparam int CW = $clog2(ZJ_CYC + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_vld,
  input logic          cmd_rdy,
  input logic [IW-1:0] gnt_idx,
  input logic          abort,
  input logic          zj_start
);
  logic          pend;
  logic [CW-1:0] zc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      zc   <= '0;
    end else if (abort) begin
      pend <= 1'b1;
      zc   <= CW'(1);
    end else if (zj_start) begin
      pend <= 1'b0;
    end else if (pend && zc != CW'(ZJ_CYC)) begin
      zc <= zc + 1'b1;
    end
  end

  // R5
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !cmd_rdy) |=> (abort || (cmd_vld && $stable(gnt_idx))));

  // R6
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);

  // R8
  window_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort || pend) |-> !cmd_vld);

  // R7
  start_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zj_start |-> (pend && zc == CW'(ZJ_CYC)));

  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zj_start |=> !zj_start);
endmodule

bind fp_cmd_arbiter fp_cmd_arbiter_chk #(.NQ(NQ), .ZJ_CYC(ZJ_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_rdy(cmd_rdy),
  .gnt_idx(gnt_idx), .abort(abort), .zj_start(zj_start)
);

// File: tb/tb_fp_cmd_arbiter.sv
module tb_fp_cmd_arbiter;
  localparam int NQ = 6;
  localparam int NB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NQ-1:0] sw_trig = '0, hw_trig = '0, hw_en = '0, q_nonempty = '1, q_eog = '1;
  logic [2*NQ-1:0] hw_mode = '0;
  logic [NQ-1:0] q_dest = '0;
  logic [NB-1:0] buf_free = '1;
  logic adc_tick = 1'b0, cmd_rdy = 1'b0;
  logic [2:0] gnt_idx, coh_qid;
  logic cmd_vld, abort, zj_start, coh_irq;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp_cmd_arbiter dut (
    .clk(clk), .rst_n(rst_n), .sw_trig(sw_trig), .hw_trig(hw_trig), .hw_en(hw_en),
    .hw_mode(hw_mode), .q_nonempty(q_nonempty), .q_dest(q_dest), .q_eog(q_eog),
    .buf_free(buf_free), .adc_tick(adc_tick), .cmd_rdy(cmd_rdy), .gnt_idx(gnt_idx),
    .cmd_vld(cmd_vld), .abort(abort), .zj_start(zj_start), .coh_irq(coh_irq),
    .coh_qid(coh_qid)
  );

  // mask, nonempty, dest, buf_free, exp_vld, exp_idx
  localparam logic [23:0] VEC [0:7] = '{
    {6'b000010, 6'b111111, 6'b000000, 2'b11, 1'b1, 3'd1},
    {6'b101100, 6'b111111, 6'b000000, 2'b11, 1'b1, 3'd2},
    {6'b101100, 6'b111011, 6'b000000, 2'b11, 1'b1, 3'd3},
    {6'b111110, 6'b111111, 6'b000110, 2'b01, 1'b1, 3'd3},
    {6'b100000, 6'b111111, 6'b000000, 2'b11, 1'b1, 3'd5},
    {6'b110000, 6'b111111, 6'b000000, 2'b00, 1'b0, 3'd0},
    {6'b000000, 6'b111111, 6'b000000, 2'b11, 1'b0, 3'd0},
    {6'b011000, 6'b111111, 6'b001000, 2'b10, 1'b1, 3'd3}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cleanup();
    cmd_rdy = 1'b1; q_eog = '1; q_nonempty = '0;
    hw_en = '0; hw_trig = '0; sw_trig = '0; adc_tick = 1'b0;
    tick(); tick(); tick();
    q_nonempty = '1; q_dest = '0; buf_free = '1; cmd_rdy = 1'b0;
  endtask

  task automatic hw_case(input string req, input logic [1:0] mode, input logic en,
                         input logic lvl, input int exp_vld);
    cleanup();
    hw_mode[9:8] = mode; hw_en[4] = en; hw_trig[4] = lvl;
    tick(); tick();
    chk(req, int'(cmd_vld), exp_vld);
    if (exp_vld == 1) chk(req, int'(gnt_idx), 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R1 vld in reset", int'(cmd_vld), 0);
    chk("R1 abort in reset", int'(abort), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 vld", int'(cmd_vld), 0);
    chk("R1 zj_start", int'(zj_start), 0);
    chk("R1 coh_irq", int'(coh_irq), 0);

    // R2 vector walk
    for (int v = 0; v < 8; v++) begin
      cleanup();
      q_nonempty = VEC[v][17:12]; q_dest = VEC[v][11:6];
      buf_free = VEC[v][5:4]; sw_trig = VEC[v][23:18];
      tick();
      sw_trig = '0;
      tick();
      chk("R2 vld", int'(cmd_vld), int'(VEC[v][3]));
      if (VEC[v][3]) chk("R2 idx", int'(gnt_idx), int'(VEC[v][2:0]));
    end

    // R3 persistence and disarm on empty
    cleanup();
    cmd_rdy = 1'b1; sw_trig[5] = 1'b1;
    tick(); sw_trig = '0;
    repeat (5) tick();
    chk("R3 still armed vld", int'(cmd_vld), 1);
    chk("R3 still armed idx", int'(gnt_idx), 5);
    q_nonempty[5] = 1'b0;
    tick(); q_nonempty[5] = 1'b1;
    tick();
    chk("R3 disarmed on empty", int'(cmd_vld), 0);

    // R4 hardware trigger modes on queue 4
    hw_case("R4 disabled rising ignored", 2'b00, 1'b0, 1'b1, 0);
    hw_case("R4 rising", 2'b00, 1'b1, 1'b1, 1);
    hw_case("R4 high level", 2'b10, 1'b1, 1'b1, 1);
    hw_case("R4 low level idle high", 2'b11, 1'b1, 1'b1, 0);
    hw_case("R4 low level", 2'b11, 1'b1, 1'b0, 1);
    hw_case("R4 falling ignores rise", 2'b01, 1'b1, 1'b1, 0);
    hw_trig[4] = 1'b0;
    tick(); tick();
    chk("R4 falling vld", int'(cmd_vld), 1);
    chk("R4 falling idx", int'(gnt_idx), 4);

    // R5 grant hold then handover at accept
    cleanup();
    sw_trig[3] = 1'b1;
    tick(); sw_trig = '0;
    tick();
    chk("R5 first grant", int'(gnt_idx), 3);
    sw_trig[1] = 1'b1;
    tick(); sw_trig = '0;
    tick();
    chk("R5 held idx", int'(gnt_idx), 3);
    chk("R5 held vld", int'(cmd_vld), 1);
    cmd_rdy = 1'b1;
    tick();
    chk("R5 handover idx", int'(gnt_idx), 1);
    chk("R5 closed group no irq", int'(coh_irq), 0);

    // R9 group broken by higher priority queue
    cleanup();
    q_eog[3] = 1'b0; cmd_rdy = 1'b1; sw_trig[3] = 1'b1;
    tick(); sw_trig = '0;
    tick(); tick();
    sw_trig[1] = 1'b1;
    tick(); sw_trig = '0;
    chk("R9 before break irq", int'(coh_irq), 0);
    chk("R9 before break idx", int'(gnt_idx), 3);
    tick();
    chk("R9 irq", int'(coh_irq), 1);
    chk("R9 qid", int'(coh_qid), 3);
    chk("R9 new idx", int'(gnt_idx), 1);
    tick();
    chk("R9 irq pulse ends", int'(coh_irq), 0);

    // R6 R8 R9 abort while a group is open, converter tick late
    cleanup();
    q_eog[3] = 1'b0; cmd_rdy = 1'b1; sw_trig[3] = 1'b1;
    tick(); sw_trig = '0;
    tick(); tick();
    cmd_rdy = 1'b0;
    tick();
    sw_trig[0] = 1'b1;
    tick(); sw_trig = '0;
    chk("R6 abort", int'(abort), 1);
    chk("R6 vld dropped", int'(cmd_vld), 0);
    chk("R9 abort irq", int'(coh_irq), 1);
    chk("R9 abort qid", int'(coh_qid), 3);
    tick();
    chk("R6 abort one cycle", int'(abort), 0);
    for (int k = 0; k < 13; k++) begin
      tick();
      chk("R8 no start yet", int'(zj_start), 0);
      chk("R8 no grant in window", int'(cmd_vld), 0);
    end
    adc_tick = 1'b1;
    tick(); adc_tick = 1'b0;
    chk("R7 start on tick", int'(zj_start), 1);
    chk("R8 no grant at start", int'(cmd_vld), 0);
    tick();
    chk("R8 resume vld", int'(cmd_vld), 1);
    chk("R8 resume idx q0", int'(gnt_idx), 0);

    // R10 retrigger of armed queue 0
    hw_mode[1:0] = 2'b10; hw_en[0] = 1'b1; hw_trig[0] = 1'b1;
    tick();
    chk("R10 hw level no abort", int'(abort), 0);
    sw_trig[0] = 1'b1;
    tick(); sw_trig = '0;
    chk("R10 sw no abort", int'(abort), 0);
    tick();
    chk("R10 grant kept", int'(gnt_idx), 0);

    // R7 exact latency with converter tick always present
    cleanup();
    adc_tick = 1'b1; sw_trig[0] = 1'b1;
    tick(); sw_trig = '0;
    chk("R6 abort second", int'(abort), 1);
    chk("R7 no start edge 0", int'(zj_start), 0);
    for (int k = 1; k < 13; k++) begin
      tick();
      chk("R7 no early start", int'(zj_start), 0);
    end
    tick();
    chk("R7 start at 13", int'(zj_start), 1);
    tick();
    chk("R7 start one cycle", int'(zj_start), 0);
    adc_tick = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule